// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Chain

This block is the digital divider path of an integer-N frequency synthesizer. A fast clock at the oscillator rate runs a main divider built from a 32/33 dual-modulus prescaler, a 5-bit swallow counter and a 10-bit program counter. Together they divide by M = 32*B + A. A slower crystal-rate clock runs an 8-bit reference divider that divides by R. The two divided streams feed a phase-frequency detector in the fast domain. The detector drives UP and DN pulses for an external charge pump and raises a lock flag once the loop has settled. With this arrangement the oscillator settles at fcrystal*(32*B + A)/R.

The A, B and R settings are static inputs. Each divider copies them at its own terminal count, so a new setting never cuts a period short. An illegal setting (B not above A, or R below 2) stops its divider and raises an error flag. Lock uses a width threshold on the detector pulses, counted in fast-clock cycles. That threshold is an input.

Top module: `synth_divider_chain`

## Requirements
- R1: With a legal setting held, `div_pulse_o` is high for exactly one fast-clock cycle every 32*B + A fast-clock cycles.
- R2: Every main period holds B prescaler cycles, each marked by a one-cycle `presc_tick_o` at its end. The first A prescaler cycles of the period last 33 fast-clock cycles and the rest last 32. The cycle that carries `div_pulse_o` also carries `presc_tick_o`.
- R3: When the copied setting has B <= A, `main_cfg_err_o` is high and the main divider emits no tick or pulse. It copies the inputs on every cycle, so a legal setting starts a fresh period on the next cycle.
- R4: With a legal R held, `ref_pulse_o` is high for one crystal cycle every R crystal cycles.
- R5: When the copied R is 0 or 1, `ref_cfg_err_o` is high and `ref_pulse_o` stays low. R is copied on every crystal cycle until it becomes legal.
- R6: A change to A, B or R takes effect only when the running period of that divider ends. The period in progress keeps its old length.
- R7: A reference pulse reaches the detector through a two-stage synchronizer. `pfd_up_o` rises on the third fast edge that samples `ref_pulse_o` high, and `pfd_dn_o` rises on the fast edge after `div_pulse_o`. When both are high they are both low one cycle later.
- R8: At each detected reference edge the cycles in which UP or DN was high since the previous edge are compared with `lock_thr_i`. `lock_o` rises on the 16th consecutive period below the threshold and falls on the first period at or above it.
- R9: While `rst_n` is low, all pulses, UP, DN and lock are low, and the dividers copy their settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast clock at the oscillator rate |
| xtal_clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| swallow_cnt_i | input | 5 | A setting (number of divide-by-33 prescaler cycles) |
| program_cnt_i | input | 10 | B setting (prescaler cycles per main period) |
| ref_ratio_i | input | 8 | R setting (reference division ratio) |
| lock_thr_i | input | 8 | Pulse-width limit for lock, in fast cycles |
| presc_tick_o | output | 1 | One-cycle mark at each prescaler cycle end |
| div_pulse_o | output | 1 | One-cycle main divider output |
| ref_pulse_o | output | 1 | One-cycle reference divider output (crystal domain) |
| pfd_up_o | output | 1 | Detector UP pulse |
| pfd_dn_o | output | 1 | Detector DN pulse |
| lock_o | output | 1 | Lock flag |
| main_cfg_err_o | output | 1 | Copied A/B setting is illegal |
| ref_cfg_err_o | output | 1 | Copied R setting is illegal |

## Verification
Tick, pulse and error outputs of each divider change one edge of their own clock after the terminal state. UP follows a reference pulse after the synchronizer, on the third fast edge. DN follows a main pulse after one edge. The lock verdict lands on the edge after the synchronized reference edge. A behavioural model advances on each rising edge of each clock and is compared with the outputs on the falling edge of the same clock, so every result is checked in the cycle it is due. Directed tasks count cycles between pulses at the ports to confirm periods, the 33/32 split, and that a setting changed part-way through a period only applies from the next period.

// File: rtl/synth_div_pkg.sv
// Shared constants for the synthesizer divider chain.
package synth_div_pkg;
    localparam int PRESC_BASE   = 32;  // low modulus of the dual-modulus prescaler
    localparam int LOCK_PERIODS = 16;  // good reference periods needed for lock
endpackage

// File: rtl/synth_main_div.sv
// Main divider: 32/33 prescaler steered by a swallow counter (A) and a
// program counter (B), dividing by 32*B + A. Assumes a static or slowly
// changing setting; A and B are copied only at the end of a period.
module synth_main_div #(
    parameter int A_W = 5,
    parameter int B_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic           presc_tick,
    output logic           div_pulse,
    output logic           cfg_err
);
    import synth_div_pkg::*;
    localparam int P_W = $clog2(PRESC_BASE + 1);

    logic [A_W-1:0] a_cur, a_cnt;
    logic [B_W-1:0] b_cur, b_cnt;
    logic [P_W-1:0] p_cnt;
    logic           cur_bad, swallow, p_last, main_tc;

    // Decode the prescaler end, the swallow phase and the period end.
    always_comb begin
        cur_bad = (b_cur <= B_W'(a_cur));
        swallow = (a_cnt != a_cur);
        p_last  = (p_cnt == (swallow ? P_W'(PRESC_BASE) : P_W'(PRESC_BASE - 1)));
        main_tc = !cur_bad && p_last && (b_cnt == b_cur - B_W'(1));
    end

    // Count prescaler and swallow/program cycles, copy settings at period end.
    always_ff @(posedge clk) begin
        if (!rst_n || cur_bad) begin
            a_cur      <= a_in;
            b_cur      <= b_in;
            a_cnt      <= '0;
            b_cnt      <= '0;
            p_cnt      <= '0;
            presc_tick <= 1'b0;
            div_pulse  <= 1'b0;
        end else begin
            presc_tick <= p_last;
            div_pulse  <= main_tc;
            if (p_last) begin
                p_cnt <= '0;
                if (main_tc) begin
                    a_cnt <= '0;
                    b_cnt <= '0;
                    a_cur <= a_in;
                    b_cur <= b_in;
                end else begin
                    b_cnt <= b_cnt + B_W'(1);
                    if (swallow) a_cnt <= a_cnt + A_W'(1);
                end
            end else begin
                p_cnt <= p_cnt + P_W'(1);
            end
        end
    end

    assign cfg_err = cur_bad;

    assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);
    assert_tick_with_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> presc_tick);
    assert_idle_when_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> (!div_pulse && !presc_tick));
    assert_copy_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(b_cur) |-> $past(main_tc || cur_bad));
endmodule

// File: rtl/synth_ref_div.sv
// Reference divider: divides the crystal clock by R (legal 2..2^R_W-1).
// R is copied only at the end of a period, or every cycle while illegal.
module synth_ref_div #(
    parameter int R_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] r_in,
    output logic           ref_pulse,
    output logic           cfg_err
);
    logic [R_W-1:0] r_cur, r_cnt;
    logic           cur_bad, ref_tc;

    // Flag illegal ratios and decode the period end.
    always_comb begin
        cur_bad = (r_cur < R_W'(2));
        ref_tc  = !cur_bad && (r_cnt == r_cur - R_W'(1));
    end

    // Count crystal cycles and reload the ratio at period end.
    always_ff @(posedge clk) begin
        if (!rst_n || cur_bad) begin
            r_cur     <= r_in;
            r_cnt     <= '0;
            ref_pulse <= 1'b0;
        end else begin
            ref_pulse <= ref_tc;
            if (ref_tc) begin
                r_cnt <= '0;
                r_cur <= r_in;
            end else begin
                r_cnt <= r_cnt + R_W'(1);
            end
        end
    end

    assign cfg_err = cur_bad;

    assert_ref_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);
    assert_ref_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> !ref_pulse);
endmodule

// File: rtl/synth_pfd_lock.sv
// Phase-frequency detector and lock detector in the fast domain. The
// reference pulse comes from the crystal domain and is assumed to stay
// high for at least two fast cycles; it is synchronized here.
module synth_pfd_lock #(
    parameter int T_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_in,
    input  logic           div_evt,
    input  logic [T_W-1:0] lock_thr,
    output logic           up,
    output logic           dn,
    output logic           lock
);
    import synth_div_pkg::*;
    localparam int G_W = $clog2(LOCK_PERIODS + 1);

    logic [2:0]     sync_q;
    logic           ref_evt, busy;
    logic [T_W-1:0] width;
    logic [G_W-1:0] good;

    assign ref_evt = sync_q[1] && !sync_q[2];
    assign busy    = up || dn;

    // Bring the reference pulse into the fast domain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ref_in};
    end

    // Edge-set UP/DN flops, both cleared one cycle after they overlap.
    always_ff @(posedge clk) begin
        if (!rst_n || (up && dn)) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            if (ref_evt) up <= 1'b1;
            if (div_evt) dn <= 1'b1;
        end
    end

    // Accumulate detector activity over one reference period, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                   width <= '0;
        else if (ref_evt)             width <= busy ? T_W'(1) : '0;
        else if (busy && width != '1) width <= width + T_W'(1);
    end

    // Judge each reference period and track consecutive good ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good <= '0;
            lock <= 1'b0;
        end else if (ref_evt) begin
            if (width < lock_thr) begin
                if (good != G_W'(LOCK_PERIODS)) good <= good + G_W'(1);
                lock <= (good >= G_W'(LOCK_PERIODS - 1));
            end else begin
                good <= '0;
                lock <= 1'b0;
            end
        end
    end

    assert_overlap_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> (!up && !dn));
    assert_lock_on_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock) |-> $past(ref_evt));
endmodule

// File: rtl/synth_divider_chain.sv
// Top of the synthesizer divider chain: main divider and detector on the
// fast clock, reference divider on the crystal clock. Assumes the fast
// clock is at least twice the crystal clock so reference pulses are seen.
module synth_divider_chain #(
    parameter int A_W = 5,
    parameter int B_W = 10,
    parameter int R_W = 8,
    parameter int T_W = 8
) (
    input  logic           vco_clk,
    input  logic           xtal_clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] swallow_cnt_i,
    input  logic [B_W-1:0] program_cnt_i,
    input  logic [R_W-1:0] ref_ratio_i,
    input  logic [T_W-1:0] lock_thr_i,
    output logic           presc_tick_o,
    output logic           div_pulse_o,
    output logic           ref_pulse_o,
    output logic           pfd_up_o,
    output logic           pfd_dn_o,
    output logic           lock_o,
    output logic           main_cfg_err_o,
    output logic           ref_cfg_err_o
);
    synth_main_div #(.A_W(A_W), .B_W(B_W)) u_main (
        .clk(vco_clk), .rst_n(rst_n), .a_in(swallow_cnt_i), .b_in(program_cnt_i),
        .presc_tick(presc_tick_o), .div_pulse(div_pulse_o), .cfg_err(main_cfg_err_o));

    synth_ref_div #(.R_W(R_W)) u_ref (
        .clk(xtal_clk), .rst_n(rst_n), .r_in(ref_ratio_i),
        .ref_pulse(ref_pulse_o), .cfg_err(ref_cfg_err_o));

    synth_pfd_lock #(.T_W(T_W)) u_pfd (
        .clk(vco_clk), .rst_n(rst_n), .ref_in(ref_pulse_o), .div_evt(div_pulse_o),
        .lock_thr(lock_thr_i), .up(pfd_up_o), .dn(pfd_dn_o), .lock(lock_o));
endmodule

// File: tb/tb_synth_divider_chain.sv
module tb_synth_divider_chain;
    localparam int VCO_PERIOD  = 10;
    localparam int XTAL_PERIOD = 40;
    localparam int WD_CYCLES   = 150000;

    logic       vco_clk = 1'b0, xtal_clk = 1'b0, rst_n = 1'b0;
    logic [4:0] a_in = 5'd0;
    logic [9:0] b_in = 10'd2;
    logic [7:0] r_in = 8'd16, thr = 8'd255;
    logic presc_tick, div_pulse, ref_pulse, up, dn, lock, merr, rerr;

    int n_checks = 0, n_fail = 0;

    synth_divider_chain dut (
        .vco_clk(vco_clk), .xtal_clk(xtal_clk), .rst_n(rst_n),
        .swallow_cnt_i(a_in), .program_cnt_i(b_in), .ref_ratio_i(r_in), .lock_thr_i(thr),
        .presc_tick_o(presc_tick), .div_pulse_o(div_pulse), .ref_pulse_o(ref_pulse),
        .pfd_up_o(up), .pfd_dn_o(dn), .lock_o(lock),
        .main_cfg_err_o(merr), .ref_cfg_err_o(rerr));

    always #(VCO_PERIOD/2)  vco_clk  = ~vco_clk;
    always #(XTAL_PERIOD/2) xtal_clk = ~xtal_clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model: fast domain.
    int m_a, m_b, m_pos, m_k, m_w, m_good;
    bit m_tick, m_div, m_up, m_dn, m_lock, m_s1, m_s2, m_s3, m_evt, m_busy, m_last, vstart;
    // Behavioural model: crystal domain.
    int m_r, m_rc;
    bit m_ref, xstart;

    always @(posedge vco_clk) begin
        if (!rst_n) begin
            m_a = a_in; m_b = b_in; m_pos = 0; m_k = 0; m_tick = 0; m_div = 0;
            m_up = 0; m_dn = 0; m_w = 0; m_good = 0; m_lock = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; vstart = 1;
        end else begin
            m_evt  = m_s2 && !m_s3;
            m_busy = m_up || m_dn;
            if (m_evt) begin
                if (m_w < int'(thr)) begin
                    if (m_good < 16) m_good++;
                    m_lock = (m_good >= 16);
                end else begin
                    m_good = 0; m_lock = 0;
                end
                m_w = m_busy ? 1 : 0;
            end else if (m_busy && m_w < 255) m_w++;
            if (m_up && m_dn) begin m_up = 0; m_dn = 0; end
            else begin m_up = m_up | m_evt; m_dn = m_dn | m_div; end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = m_ref;
            if (m_b <= m_a) begin
                m_a = a_in; m_b = b_in; m_pos = 0; m_k = 0; m_tick = 0; m_div = 0;
            end else begin
                m_last = (m_pos == ((m_k < m_a) ? 32 : 31));
                m_tick = m_last;
                m_div  = m_last && (m_k == m_b - 1);
                if (m_last) begin
                    m_pos = 0;
                    if (m_div) begin m_k = 0; m_a = a_in; m_b = b_in; end
                    else m_k++;
                end else m_pos++;
            end
        end
    end

    always @(posedge xtal_clk) begin
        if (!rst_n) begin
            m_r = r_in; m_rc = 0; m_ref = 0; xstart = 1;
        end else if (m_r < 2) begin
            m_r = r_in; m_rc = 0; m_ref = 0;
        end else begin
            m_ref = (m_rc == m_r - 1);
            if (m_ref) begin m_rc = 0; m_r = r_in; end
            else m_rc++;
        end
    end

    // Compare the fast-domain outputs with the model on every cycle.
    bit prev_both = 0;
    always @(negedge vco_clk) if (vstart) begin
        chk("R1", "div_pulse", div_pulse, m_div);
        chk("R2", "presc_tick", presc_tick, m_tick);
        chk("R3", "main_cfg_err", merr, (m_b <= m_a));
        chk("R7", "pfd_up", up, m_up);
        chk("R7", "pfd_dn", dn, m_dn);
        chk("R8", "lock", lock, m_lock);
        if (prev_both) chk("R7", "overlap cleared", up | dn, 0);
        prev_both = up && dn;
    end

    // Compare the crystal-domain outputs with the model on every cycle.
    always @(negedge xtal_clk) if (xstart) begin
        chk("R4", "ref_pulse", ref_pulse, m_ref);
        chk("R5", "ref_cfg_err", rerr, (m_r < 2));
    end

    task automatic vwait(input int n);
        repeat (n) @(negedge vco_clk);
    endtask

    task automatic drive_main(input int a, input int b);
        @(negedge vco_clk); #2; a_in = 5'(a); b_in = 10'(b);
    endtask

    task automatic wait_div();
        int g = 0;
        do begin @(negedge vco_clk); g++; end while (!div_pulse && g < 20000);
    endtask

    // Measure one main period: length, ticks and 33-cycle prescaler cycles.
    task automatic measure_main(output int len, output int ticks, output int long33);
        int gap = 0;
        wait_div();
        len = 0; ticks = 0; long33 = 0;
        do begin
            @(negedge vco_clk); len++; gap++;
            if (presc_tick) begin ticks++; if (gap == 33) long33++; gap = 0; end
        end while (!div_pulse && len < 20000);
    endtask

    task automatic measure_ref(output int len);
        int g = 0;
        do begin @(negedge xtal_clk); g++; end while (!ref_pulse && g < 5000);
        len = 0;
        do begin @(negedge xtal_clk); len++; end while (!ref_pulse && len < 5000);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(WD_CYCLES * VCO_PERIOD);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int len, ticks, l33, cnt;
        vwait(20);
        // R9: reset state.
        chk("R9", "reset div_pulse", div_pulse, 0);
        chk("R9", "reset up|dn", up | dn, 0);
        chk("R9", "reset lock", lock, 0);
        chk("R9", "reset ref_pulse", ref_pulse, 0);
        chk("R9", "reset errors", merr | rerr, 0);
        #2; rst_n = 1'b1;

        // R1/R2: A=0, B=2 gives 64 cycles, two 32-cycle prescaler cycles.
        measure_main(len, ticks, l33);
        chk("R1", "period A0 B2", len, 64);
        chk("R2", "ticks A0 B2", ticks, 2);
        chk("R2", "33-cycles A0 B2", l33, 0);
        measure_ref(len);
        chk("R4", "ref period R16", len, 16);

        // R8: matched frequencies with a wide threshold lock.
        vwait(24 * 64);
        chk("R8", "lock after settle", lock, 1);

        // R6: change mid-period, the running period keeps 64.
        wait_div();
        cnt = 0;
        repeat (10) begin @(negedge vco_clk); cnt++; end
        #2; a_in = 5'd5; b_in = 10'd7; thr = 8'd4;
        do begin @(negedge vco_clk); cnt++; end while (!div_pulse && cnt < 20000);
        chk("R6", "old period kept", cnt, 64);
        measure_main(len, ticks, l33);
        chk("R1", "period A5 B7", len, 229);
        chk("R2", "ticks A5 B7", ticks, 7);
        chk("R2", "33-cycles A5 B7", l33, 5);

        // R8: mismatch with a tight threshold drops lock.
        vwait(600);
        chk("R8", "lock dropped", lock, 0);

        // R6/R4: new reference ratio.
        @(negedge xtal_clk); #2; r_in = 8'd10;
        measure_ref(len);
        measure_ref(len);
        chk("R4", "ref period R10", len, 10);

        // R3: B equal to A is illegal, divider goes idle.
        drive_main(3, 3);
        wait_div();
        vwait(2);
        chk("R3", "main error flag", merr, 1);
        cnt = 0;
        repeat (300) begin @(negedge vco_clk); if (div_pulse | presc_tick) cnt++; end
        chk("R3", "no output while illegal", cnt, 0);
        drive_main(1, 4);
        measure_main(len, ticks, l33);
        chk("R3", "restart period A1 B4", len, 129);
        chk("R2", "33-cycles A1 B4", l33, 1);

        // R5: R of 1 and 0 are illegal.
        @(negedge xtal_clk); #2; r_in = 8'd1;
        repeat (12) @(negedge xtal_clk);
        chk("R5", "ref error R1", rerr, 1);
        #2; r_in = 8'd0;
        cnt = 0;
        repeat (30) begin @(negedge xtal_clk); if (ref_pulse) cnt++; end
        chk("R5", "no ref pulse while illegal", cnt, 0);
        chk("R5", "ref error R0", rerr, 1);
        #2; r_in = 8'd3;
        measure_ref(len);
        chk("R5", "ref period R3", len, 3);

        // R8: relock after restoring a matched setting.
        drive_main(0, 2);
        thr = 8'd255;
        @(negedge xtal_clk); #2; r_in = 8'd16;
        vwait(30 * 64);
        chk("R8", "relock", lock, 1);
        finish_run();
    end
endmodule